// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block gives a processor two 8-bit input ports, group A and group B. Each port is filled by a peripheral through a simple handshake. The peripheral puts a byte on its data lines and pulls an active-low strobe. While the strobe is low, the block copies the byte into a holding register and raises a buffer-full flag. Once the strobe is back high, the block can raise an interrupt request if that group's interrupt enable is set. The processor then reads the port through an active-low read strobe:
- the falling edge of the read drops the interrupt;
- the rising edge of the read empties the buffer-full flag.

The peripheral strobes and the processor read strobes may be asynchronous. Each one passes through a two-flop synchroniser before any edge or level is acted on.

Configuration arrives as single-cycle writes of a control byte.
- A byte with the top bit set is a mode word. It decides whether each group works as a strobed input.
- A byte with the top bit clear is a bit set/reset command. It sets or clears one bit of the handshake control lines. Bit 4 is group A's interrupt enable and bit 2 is group B's.

Top module: `ppiStrobedIn`

## Requirements
- R1: After reset, every buffer-full flag, interrupt request, interrupt enable and holding register is 0, and neither group is a strobed input.
- R2: A control write with data bit 7 = 1 is a mode word. Group A becomes a strobed input only when bits 6:5 = 01 and bit 4 = 1. Group B becomes a strobed input only when bit 2 = 1 and bit 1 = 1. A group that is not a strobed input ignores its strobe: its register keeps its value and its flags stay 0.
- R3: While a group's synchronised strobe is low, the group's register loads the peripheral byte and the buffer-full flag sets. The flag is first seen high after the third rising clock edge that follows the strobe pin falling.
- R4: The buffer-full flag stays high while the read strobe is low. It clears after the synchronised rising edge of the read strobe.
- R5: The interrupt request sets while all of these hold: the synchronised strobe is high, the buffer-full flag is high, the interrupt enable is 1 and the read strobe is idle. The request is never high without the buffer-full flag.
- R6: The interrupt request clears on the synchronised falling edge of the read strobe, while the buffer-full flag is still high.
- R7: A control write with bit 7 = 0 is a bit set/reset command: bits 3:1 select a bit and bit 0 gives its new value. Bit number 4 is group A's interrupt enable and bit number 2 is group B's. Other bit numbers change neither flag. Clearing an enable drops that group's interrupt request in the same cycle, so the request is never high without its enable.
- R8: A strobe that arrives while the buffer-full flag is already set overwrites the register, and the flag stays set.
- R9: Any mode word clears the buffer-full flags, interrupt requests and interrupt enables of both groups. It leaves the registers' contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | One-cycle control byte write strobe |
| cfgData | input | 8 | Control byte: mode word or bit set/reset command |
| stbAN | input | 1 | Group A peripheral strobe, active low, asynchronous |
| stbBN | input | 1 | Group B peripheral strobe, active low, asynchronous |
| rdAN | input | 1 | Group A processor read strobe, active low, asynchronous |
| rdBN | input | 1 | Group B processor read strobe, active low, asynchronous |
| perDataA | input | 8 | Group A peripheral byte |
| perDataB | input | 8 | Group B peripheral byte |
| busDataA | output | 8 | Group A holding register, read by the processor |
| busDataB | output | 8 | Group B holding register, read by the processor |
| ibfA | output | 1 | Group A buffer full |
| intrA | output | 1 | Group A interrupt request |
| ibfB | output | 1 | Group B buffer full |
| intrB | output | 1 | Group B interrupt request |

## Verification
A wrong buffer-full flag appears at the port on the very clock edge where it goes wrong. Such an error either shows up as an interrupt request with no full buffer, or as a buffer that empties before the read strobe has risen. A request that stays high across a read appears one edge after the synchronised falling edge of the read. A stale enable shows up the next time a strobe completes on that group. A register that loads outside a strobe changes the read data at once. The bench therefore samples every flag and data output after each handshake step, and checks the exact edge at which the flag first rises.

// File: rtl/ppiStrobedInPkg.sv
package ppiStrobedInPkg;
  localparam int DATA_W      = 8;
  localparam int GRP_N       = 2;
  localparam int SYNC_STAGES = 2;
  localparam int CFG_W       = 8;
  localparam int BIT_SEL_W   = 3;

  // handshake control line holding each group's interrupt enable
  localparam logic [BIT_SEL_W-1:0] INTE_LINE_A = 3'd4;
  localparam logic [BIT_SEL_W-1:0] INTE_LINE_B = 3'd2;

  function automatic logic [BIT_SEL_W-1:0] inteLine(input int grp);
    return (grp == 0) ? INTE_LINE_A : INTE_LINE_B;
  endfunction

  // strobes from control to datapath
  typedef struct packed {
    logic [GRP_N-1:0] load;
  } dpCmd_t;
endpackage

// File: rtl/ppiSync.sv
module ppiSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '1;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/ppiCtrl.sv
module ppiCtrl
  import ppiStrobedInPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [GRP_N-1:0] stbS,
  input  logic [GRP_N-1:0] rdS,
  output dpCmd_t           cmd,
  output logic [GRP_N-1:0] ibf,
  output logic [GRP_N-1:0] intr,
  output logic [GRP_N-1:0] inte
);
  logic [GRP_N-1:0] modeOn, rdPrev;
  logic [GRP_N-1:0] modeSel, inteNext, ibfNext, intrNext, loadNow;
  logic             modeWr, bsrWr;

  assign modeWr = cfgWr & cfgData[CFG_W-1];
  assign bsrWr  = cfgWr & ~cfgData[CFG_W-1];

  // mode word decode (R2)
  assign modeSel[0] = (cfgData[6:5] == 2'b01) & cfgData[4];
  assign modeSel[1] = cfgData[2] & cfgData[1];

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic rdRise, rdFall, setIntr, bsrHit;
    assign rdRise  = rdS[g] & ~rdPrev[g];
    assign rdFall  = ~rdS[g] & rdPrev[g];
    assign bsrHit  = bsrWr & (cfgData[BIT_SEL_W:1] == inteLine(g));
    assign loadNow[g] = modeOn[g] & ~stbS[g];
    assign setIntr = modeOn[g] & stbS[g] & ibf[g] & rdS[g] & rdPrev[g];

    assign inteNext[g] = modeWr ? 1'b0 : (bsrHit ? cfgData[0] : inte[g]);
    assign ibfNext[g]  = modeWr ? 1'b0 :
                         loadNow[g] ? 1'b1 :
                         rdRise ? 1'b0 : ibf[g];
    assign intrNext[g] = modeWr ? 1'b0 :
                         ((rdFall ? 1'b0 : (intr[g] | setIntr)) & inteNext[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeOn <= '0;
      inte   <= '0;
      ibf    <= '0;
      intr   <= '0;
      rdPrev <= '1;
    end else begin
      if (modeWr) modeOn <= modeSel;
      inte   <= inteNext;
      ibf    <= ibfNext;
      intr   <= intrNext;
      rdPrev <= rdS;
    end
  end

  assign cmd.load = loadNow;
endmodule

// File: rtl/ppiData.sv
module ppiData
  import ppiStrobedInPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCmd_t                       cmd,
  input  logic [GRP_N-1:0][DATA_W-1:0] perData,
  output logic [GRP_N-1:0][DATA_W-1:0] held
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0;
    end else begin
      for (int g = 0; g < GRP_N; g++)
        if (cmd.load[g]) held[g] <= perData[g];
    end
  end
endmodule

// File: rtl/ppiStrobedIn.sv
module ppiStrobedIn
  import ppiStrobedInPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              stbAN,
  input  logic              stbBN,
  input  logic              rdAN,
  input  logic              rdBN,
  input  logic [DATA_W-1:0] perDataA,
  input  logic [DATA_W-1:0] perDataB,
  output logic [DATA_W-1:0] busDataA,
  output logic [DATA_W-1:0] busDataB,
  output logic              ibfA,
  output logic              intrA,
  output logic              ibfB,
  output logic              intrB
);
  localparam int SYNC_W = 2 * GRP_N;

  logic [SYNC_W-1:0]              syncIn, syncOut;
  logic [GRP_N-1:0]               stbSync, rdSync, ibf, intr, inte;
  logic [GRP_N-1:0][DATA_W-1:0]   perData, held;
  dpCmd_t                         cmd;

  assign syncIn  = {rdBN, rdAN, stbBN, stbAN};
  assign stbSync = syncOut[GRP_N-1:0];
  assign rdSync  = syncOut[SYNC_W-1:GRP_N];
  assign perData = {perDataB, perDataA};

  ppiSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(syncIn), .syncOut(syncOut)
  );

  ppiCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .stbS(stbSync), .rdS(rdSync), .cmd(cmd),
    .ibf(ibf), .intr(intr), .inte(inte)
  );

  ppiData u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .perData(perData), .held(held)
  );

  assign busDataA = held[0];
  assign busDataB = held[1];
  assign ibfA     = ibf[0];
  assign ibfB     = ibf[1];
  assign intrA    = intr[0];
  assign intrB    = intr[1];
endmodule

// File: rtl/ppiStrobedInChk.sv
module ppiStrobedInChk
  import ppiStrobedInPkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [GRP_N-1:0]             stbSync,
  input logic [GRP_N-1:0]             rdSync,
  input logic [GRP_N-1:0]             ibf,
  input logic [GRP_N-1:0]             intr,
  input logic [GRP_N-1:0]             inte,
  input logic [GRP_N-1:0][DATA_W-1:0] held
);
  logic [GRP_N-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '1;
    else       rdQ <= rdSync;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_chk
    p_intr_needs_ibf_r5: assert property (@(posedge clk) disable iff (!rstN)
      intr[g] |-> ibf[g]);
    p_intr_needs_inte_r7: assert property (@(posedge clk) disable iff (!rstN)
      intr[g] |-> inte[g]);
    p_ibf_set_by_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ibf[g]) |-> !$past(stbSync[g]));
    p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
      $past(stbSync[g]) |-> $stable(held[g]));
    p_intr_drop_on_read_r6: assert property (@(posedge clk) disable iff (!rstN)
      (rdQ[g] && !rdSync[g]) |=> !intr[g]);
  end
endmodule

bind ppiStrobedIn ppiStrobedInChk u_chk (
  .clk(clk), .rstN(rstN), .stbSync(stbSync), .rdSync(rdSync),
  .ibf(ibf), .intr(intr), .inte(inte), .held(held)
);

// File: tb/ppiStrobedIn_tb.sv
module ppiStrobedIn_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic       stbAN = 1'b1, stbBN = 1'b1, rdAN = 1'b1, rdBN = 1'b1;
  logic [7:0] perDataA = '0, perDataB = '0;
  logic [7:0] busDataA, busDataB;
  logic       ibfA, intrA, ibfB, intrB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ppiStrobedIn u_dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .stbAN(stbAN), .stbBN(stbBN), .rdAN(rdAN), .rdBN(rdBN),
    .perDataA(perDataA), .perDataB(perDataB),
    .busDataA(busDataA), .busDataB(busDataB),
    .ibfA(ibfA), .intrA(intrA), .ibfB(ibfB), .intrB(intrB)
  );

  // op: 0 mode word, 1 bit set/reset, 2 strobe, 3 read
  // fields: op[30:29] grp[28] arg[27:20] flags{ibfA,intrA,ibfB,intrB}[19:16] busA[15:8] busB[7:0]
  localparam int NV = 19;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'hB6, 4'b0000, 8'h00, 8'h00},
    {2'd2, 1'b0, 8'h5A, 4'b1000, 8'h5A, 8'h00},
    {2'd3, 1'b0, 8'h00, 4'b0000, 8'h5A, 8'h00},
    {2'd1, 1'b0, 8'h09, 4'b0000, 8'h5A, 8'h00},
    {2'd2, 1'b0, 8'hC3, 4'b1100, 8'hC3, 8'h00},
    {2'd3, 1'b0, 8'h00, 4'b0000, 8'hC3, 8'h00},
    {2'd1, 1'b0, 8'h05, 4'b0000, 8'hC3, 8'h00},
    {2'd2, 1'b1, 8'h81, 4'b0011, 8'hC3, 8'h81},
    {2'd2, 1'b1, 8'h7E, 4'b0011, 8'hC3, 8'h7E},
    {2'd1, 1'b0, 8'h04, 4'b0010, 8'hC3, 8'h7E},
    {2'd1, 1'b0, 8'h0D, 4'b0010, 8'hC3, 8'h7E},
    {2'd3, 1'b1, 8'h00, 4'b0000, 8'hC3, 8'h7E},
    {2'd0, 1'b0, 8'h80, 4'b0000, 8'hC3, 8'h7E},
    {2'd2, 1'b0, 8'h11, 4'b0000, 8'hC3, 8'h7E},
    {2'd0, 1'b0, 8'hB6, 4'b0000, 8'hC3, 8'h7E},
    {2'd2, 1'b0, 8'h22, 4'b1000, 8'h22, 8'h7E},
    {2'd1, 1'b0, 8'h09, 4'b1100, 8'h22, 8'h7E},
    {2'd0, 1'b0, 8'hB6, 4'b0000, 8'h22, 8'h7E},
    {2'd2, 1'b1, 8'h99, 4'b0010, 8'h22, 8'h99}
  };
  string vecReq [NV] = '{"R2", "R3", "R4", "R7", "R5", "R6", "R7", "R5", "R8",
                         "R7", "R7", "R4", "R2", "R2", "R9", "R9", "R5", "R9", "R9"};

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic [3:0] fl,
                          input logic [7:0] ba, input logic [7:0] bb);
    check(req, "flags", {4'b0, ibfA, intrA, ibfB, intrB}, {4'b0, fl});
    check(req, "busA", busDataA, ba);
    check(req, "busB", busDataB, bb);
  endtask

  task automatic cfg(input logic [7:0] w);
    @(negedge clk); cfgWr = 1'b1; cfgData = w;
    @(negedge clk); cfgWr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe(input bit grp, input logic [7:0] d);
    @(negedge clk);
    if (grp) begin perDataB = d; stbBN = 1'b0; end
    else     begin perDataA = d; stbAN = 1'b0; end
    repeat (3) @(negedge clk);
    stbAN = 1'b1; stbBN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic readPort(input bit grp);
    @(negedge clk);
    if (grp) rdBN = 1'b0; else rdAN = 1'b0;
    repeat (4) @(negedge clk);
    rdAN = 1'b1; rdBN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state
    checkAll("R1", 4'b0000, 8'h00, 8'h00);
    // R1/R2: no strobed mode after reset, strobe ignored
    strobe(1'b0, 8'hEE);
    checkAll("R1", 4'b0000, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      case (v[30:29])
        2'd0: cfg(v[27:20]);
        2'd1: cfg(v[27:20]);
        2'd2: strobe(v[28], v[27:20]);
        default: readPort(v[28]);
      endcase
      checkAll(vecReq[i], v[19:16], v[15:8], v[7:0]);
    end

    // R3: exact latency of the buffer-full flag
    doReset();
    cfg(8'hB6);
    @(negedge clk); perDataA = 8'h3C; stbAN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3", "ibfA after 2 edges", {7'b0, ibfA}, 8'h00);
    @(negedge clk);
    check("R3", "ibfA after 3 edges", {7'b0, ibfA}, 8'h01);
    check("R3", "busA loaded", busDataA, 8'h3C);
    stbAN = 1'b1;
    repeat (6) @(negedge clk);

    // R5/R6/R4: request set, dropped by read fall, flag held until read rise
    cfg(8'h09);
    check("R5", "intrA set", {7'b0, intrA}, 8'h01);
    @(negedge clk); rdAN = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", "intrA during read", {7'b0, intrA}, 8'h00);
    check("R4", "ibfA during read", {7'b0, ibfA}, 8'h01);
    rdAN = 1'b1;
    repeat (5) @(negedge clk);
    check("R4", "ibfA after read", {7'b0, ibfA}, 8'h00);
    check("R5", "intrA after read", {7'b0, intrA}, 8'h00);

    // R2: group B off when its direction bit selects output
    cfg(8'hB4);
    strobe(1'b1, 8'h55);
    check("R2", "ibfB output mode", {7'b0, ibfB}, 8'h00);
    check("R2", "busB output mode", busDataB, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule